// File: doc/BRIEF.md
# Banked register-file address unit

This block turns the short operand field of an 8-bit processor instruction into a full 12-bit data-memory address. The memory holds 4 KB and is split into sixteen 256-byte banks. The instruction carries only an 8-bit field and a select bit. In banked mode, a 4-bit bank register supplies the upper address bits. In access mode, a fixed split window is used: the lower half of the field reaches the bottom of memory and the upper half reaches the top page, which holds the special-function registers. The bank register has no effect in access mode.

Three pointer registers support indirect access. Each pointer owns two virtual locations near the top of memory, one plain and one post-increment. These are not backed by storage. When a resolved address lands on one of them, the access goes to the address held in that pointer. The unit also drives the read and write strobes for the memory array, and a flag that sends the result to the working register instead of memory. All outputs follow the current-cycle inputs combinationally. Bank and pointer updates take effect at the next clock edge.

Top module: `rf_addr_unit`

## Requirements
- R1: With `op_banked`=1, the direct address is `{bank, op_field}`, where bank is the bank register value before any load in the same cycle.
- R2: With `op_banked`=0 and `op_field` in 0x00..0x7F, the direct address equals `op_field` (upper 4 bits zero).
- R3: With `op_banked`=0 and `op_field` in 0x80..0xFF, the direct address is 0xF00 plus `op_field`, giving 0xF80..0xFFF.
- R4: `bank_ld` writes `bank_val` into the bank register at the clock edge. A banked access in the same cycle still uses the old value. The bank register resets to 0.
- R5: `ptr_ld` writes the 12-bit `ptr_val` into pointer `ptr_sel` (0, 1 or 2) at the clock edge. `ptr_sel`=3 changes no pointer. All pointers reset to 0.
- R6: A direct address of 0xFE0, 0xFE4 or 0xFE8 is the plain indirect location of pointer 0, 1 or 2. `mem_addr` becomes that pointer's value, and the pointer is not changed.
- R7: A direct address of 0xFE1, 0xFE5 or 0xFE9 is the post-increment location of pointer 0, 1 or 2. `mem_addr` takes the current pointer value, and the pointer then advances by 1 modulo 4096 at the clock edge. If a pointer load targets the same pointer in the same cycle, the load takes priority.
- R8: If an indirect access reaches a pointer that holds one of the six indirect-location addresses, `mem_rd` and `mem_wr` stay low. `rd_zero` is then raised when a read is requested, meaning the operand is taken as 0. A post-increment still advances the pointer.
- R9: `mem_rd` = `op_valid & op_rd` and `mem_wr` = `op_valid & op_wr & op_dest`, except in the R8 case. `wb_to_w` = `op_valid & op_wr & ~op_dest`. When `op_valid` is low, no strobe is raised and no pointer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A register-file operation is presented this cycle |
| op_field | input | 8 | Address field of the instruction |
| op_banked | input | 1 | 1 = banked, 0 = split access window |
| op_dest | input | 1 | 1 = result to memory, 0 = result to working register |
| op_rd | input | 1 | Operation reads its memory operand |
| op_wr | input | 1 | Operation produces a result |
| bank_ld | input | 1 | Load the bank register |
| bank_val | input | 4 | New bank number |
| ptr_ld | input | 1 | Load a pointer register |
| ptr_sel | input | 2 | Pointer to load |
| ptr_val | input | 12 | New pointer value |
| mem_addr | output | 12 | Resolved data-memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| wb_to_w | output | 1 | Result goes to the working register |
| rd_zero | output | 1 | Nested indirect read: operand is 0 |

## Verification
The bench builds the unit with its default parameters: 12-bit addresses, an 8-bit field, three pointers, and indirect locations at 0xFE0 with a stride of 4. With this small configuration it can sweep every field value in access mode and every field value under every one of the sixteen banks. That sweep reaches all six indirect locations through bank 15 as well as through the access window. Directed sequences then cover pointer wrap at 0xFFF, load-versus-increment priority, pointers aimed at indirect locations, and every strobe combination. A long seeded random run mixes bank loads, pointer loads and operations in the same cycles.

// File: rtl/rf_addr_unit.sv
module rf_addr_unit #(
  parameter int AW         = 12,
  parameter int FW         = 8,
  parameter int NPTR       = 3,
  parameter int IND_BASE   = 'hFE0,
  parameter int IND_STRIDE = 4,
  localparam int BW        = AW - FW,
  localparam int SW        = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [FW-1:0] op_field,
  input  logic          op_banked,
  input  logic          op_dest,
  input  logic          op_rd,
  input  logic          op_wr,
  input  logic          bank_ld,
  input  logic [BW-1:0] bank_val,
  input  logic          ptr_ld,
  input  logic [SW-1:0] ptr_sel,
  input  logic [AW-1:0] ptr_val,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          wb_to_w,
  output logic          rd_zero
);

  logic [BW-1:0]   bsr_q;
  logic [AW-1:0]   ptr_q [NPTR];
  logic [AW-1:0]   dir_addr;
  logic [AW-1:0]   tgt;
  logic [NPTR-1:0] hit_plain;
  logic [NPTR-1:0] hit_inc;
  logic            ind;
  logic            nested;

  function automatic logic is_alias(input logic [AW-1:0] a);
    logic r;
    r = 1'b0;
    for (int n = 0; n < NPTR; n++)
      if (a == AW'(IND_BASE + n * IND_STRIDE) || a == AW'(IND_BASE + n * IND_STRIDE + 1))
        r = 1'b1;
    return r;
  endfunction

  // split window: sign-extending the field puts its upper half on the top page
  assign dir_addr = op_banked ? {bsr_q, op_field} : {{BW{op_field[FW-1]}}, op_field};

  for (genvar n = 0; n < NPTR; n++) begin : g_dec
    assign hit_plain[n] = (dir_addr == AW'(IND_BASE + n * IND_STRIDE));
    assign hit_inc[n]   = (dir_addr == AW'(IND_BASE + n * IND_STRIDE + 1));
  end

  always_comb begin
    tgt = '0;
    for (int n = 0; n < NPTR; n++)
      if (hit_plain[n] || hit_inc[n]) tgt = ptr_q[n];
  end

  assign ind      = |(hit_plain | hit_inc);
  assign nested   = ind && is_alias(tgt);
  assign mem_addr = ind ? tgt : dir_addr;
  assign mem_rd   = op_valid && op_rd && !nested;
  assign mem_wr   = op_valid && op_wr && op_dest && !nested;
  assign wb_to_w  = op_valid && op_wr && !op_dest;
  assign rd_zero  = op_valid && op_rd && nested;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsr_q <= '0;
      for (int n = 0; n < NPTR; n++) ptr_q[n] <= '0;
    end else begin
      if (bank_ld) bsr_q <= bank_val;
      for (int n = 0; n < NPTR; n++) begin
        if (ptr_ld && int'(ptr_sel) == n) ptr_q[n] <= ptr_val;
        else if (op_valid && hit_inc[n])  ptr_q[n] <= ptr_q[n] + 1'b1;
      end
    end
  end

  p_bank_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld |=> bsr_q == $past(bank_val));

  p_nested_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_zero |-> !mem_rd && !mem_wr);

  p_wb_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && wb_to_w));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !mem_rd && !mem_wr && !wb_to_w && !rd_zero);

  for (genvar n = 0; n < NPTR; n++) begin : g_chk
    p_ptr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_ld && int'(ptr_sel) == n |=> ptr_q[n] == $past(ptr_val));
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ptr_ld && int'(ptr_sel) == n) && !(op_valid && hit_inc[n]) |=> $stable(ptr_q[n]));
    p_postinc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && hit_inc[n] && !(ptr_ld && int'(ptr_sel) == n)
      |=> ptr_q[n] == AW'($past(ptr_q[n]) + 1'b1));
  end

endmodule

// File: tb/sim_rf_addr_unit.sv
module sim_rf_addr_unit;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0, op_banked = 1'b0, op_dest = 1'b0, op_rd = 1'b0, op_wr = 1'b0;
  logic [7:0] op_field = '0;
  logic bank_ld = 1'b0, ptr_ld = 1'b0;
  logic [3:0] bank_val = '0;
  logic [1:0] ptr_sel = '0;
  logic [11:0] ptr_val = '0;
  logic [11:0] mem_addr;
  logic mem_rd, mem_wr, wb_to_w, rd_zero;

  int checks = 0;
  int fails = 0;
  logic [3:0]  bank_m = '0;
  logic [11:0] ptr_m [3];

  always #(PERIOD/2) clk = ~clk;

  rf_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_field(op_field),
    .op_banked(op_banked), .op_dest(op_dest), .op_rd(op_rd), .op_wr(op_wr),
    .bank_ld(bank_ld), .bank_val(bank_val), .ptr_ld(ptr_ld), .ptr_sel(ptr_sel),
    .ptr_val(ptr_val), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_to_w(wb_to_w), .rd_zero(rd_zero)
  );

  function automatic bit alias_addr(input logic [11:0] a);
    for (int n = 0; n < 3; n++)
      if (a == 12'hFE0 + 12'(4 * n) || a == 12'hFE1 + 12'(4 * n)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic op(input bit v, input logic [7:0] f, input bit bk, input bit d,
                    input bit r, input bit w, input bit bl, input logic [3:0] bv,
                    input bit pl, input logic [1:0] ps, input logic [11:0] pv,
                    input string tag);
    logic [11:0] dir, ea;
    int pn;
    bit inc, nest;
    logic [15:0] act, exp;
    op_valid = v; op_field = f; op_banked = bk; op_dest = d; op_rd = r; op_wr = w;
    bank_ld = bl; bank_val = bv; ptr_ld = pl; ptr_sel = ps; ptr_val = pv;
    #1;
    if (bk) dir = {bank_m, f};
    else if (f < 8'h80) dir = {4'h0, f};
    else dir = 12'hF00 + {4'h0, f};
    pn = -1; inc = 1'b0;
    for (int n = 0; n < 3; n++) begin
      if (dir == 12'hFE0 + 12'(4 * n)) pn = n;
      if (dir == 12'hFE1 + 12'(4 * n)) begin pn = n; inc = 1'b1; end
    end
    ea = (pn >= 0) ? ptr_m[pn] : dir;
    nest = (pn >= 0) && alias_addr(ea);
    exp = {ea, v && r && !nest, v && w && d && !nest, v && w && !d, v && r && nest};
    act = {mem_addr, mem_rd, mem_wr, wb_to_w, rd_zero};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: addr/rd/wr/w/zero actual %h %b%b%b%b expected %h %b%b%b%b",
               tag, act[15:4], act[3], act[2], act[1], act[0],
               exp[15:4], exp[3], exp[2], exp[1], exp[0]);
    end
    @(posedge clk);
    if (bl) bank_m = bv;
    for (int n = 0; n < 3; n++) begin
      if (pl && ps == 2'(n)) ptr_m[n] = pv;
      else if (v && inc && pn == n) ptr_m[n] = ptr_m[n] + 12'd1;
    end
    @(negedge clk);
  endtask

  task automatic acc(input logic [7:0] f, input bit bk, input string tag);
    op(1, f, bk, 1, 1, 1, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic ldp(input logic [1:0] s, input logic [11:0] val, input string tag);
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, s, val, tag);
  endtask

  function automatic string tag_of(input logic [7:0] f, input bit bk, input logic [3:0] b);
    if (bk && b == 4'hF && f >= 8'hE0 && f <= 8'hE9) return "R6/R7 via bank";
    if (!bk && f >= 8'hE0 && f <= 8'hE9) return "R6/R7 via window";
    if (bk) return "R1";
    if (f < 8'h80) return "R2";
    return "R3";
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] rb;
    logic [11:0] rv;
    for (int n = 0; n < 3; n++) ptr_m[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: bank 0 (R4) and pointers 0 (R5)
    acc(8'h34, 1, "R4 reset bank");
    acc(8'hE0, 0, "R5 reset ptr0");
    acc(8'hE4, 0, "R5 reset ptr1");
    acc(8'hE8, 0, "R5 reset ptr2");

    // give pointers harmless values so the sweeps stay non-nested
    ldp(0, 12'h123, "R5"); ldp(1, 12'h456, "R5"); ldp(2, 12'h789, "R5");

    // R2 R3 full window sweep
    for (int f = 0; f < 256; f++) acc(8'(f), 0, tag_of(8'(f), 0, 0));

    // R1 all banks, all fields
    for (int b = 0; b < 16; b++) begin
      op(0, 0, 0, 0, 0, 0, 1, 4'(b), 0, 0, 0, "R4");
      for (int f = 0; f < 256; f++) op(1, 8'(f), 1, 0, 1, 0, 0, 0, 0, 0, 0, tag_of(8'(f), 1, 4'(b)));
    end

    // R4 same-cycle load: access uses the old bank, next access the new one
    op(0, 0, 0, 0, 0, 0, 1, 4'h3, 0, 0, 0, "R4");
    op(1, 8'h10, 1, 1, 1, 1, 1, 4'hA, 0, 0, 0, "R4 same-cycle old bank");
    acc(8'h10, 1, "R4 new bank");
    acc(8'h10, 0, "R2 window ignores bank");
    acc(8'h90, 0, "R3 window ignores bank");

    // R5 select 3 loads nothing
    op(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 12'hABC, "R5 sel3");
    acc(8'hE0, 0, "R5 ptr0 kept");
    acc(8'hE4, 0, "R5 ptr1 kept");
    acc(8'hE8, 0, "R5 ptr2 kept");

    // R6 plain indirect does not move the pointer
    acc(8'hE4, 0, "R6");
    acc(8'hE4, 0, "R6 repeat");

    // R7 wrap and priority
    ldp(1, 12'hFFF, "R5");
    acc(8'hE5, 0, "R7 at FFF");
    acc(8'hE4, 0, "R7 wrapped to 000");
    acc(8'hE5, 0, "R7 from 000");
    acc(8'hE4, 0, "R7 now 001");
    op(1, 8'hE9, 0, 1, 1, 1, 0, 0, 1, 2'd2, 12'h300, "R7 load vs inc");
    acc(8'hE8, 0, "R7 load wins");
    op(1, 8'hE9, 0, 1, 1, 1, 0, 0, 1, 2'd0, 12'h055, "R7 other load");
    acc(8'hE8, 0, "R7 inc kept");
    acc(8'hE0, 0, "R7 other ptr loaded");
    op(0, 8'hE1, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R9 idle no inc");
    acc(8'hE0, 0, "R9 idle ptr held");

    // R8 nested indirect
    ldp(0, 12'hFE4, "R5");
    op(1, 8'hE0, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R8 nested rd/wr");
    op(1, 8'hE0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R8 nested rd");
    op(1, 8'hE0, 0, 1, 0, 1, 0, 0, 0, 0, 0, "R8 nested wr");
    ldp(2, 12'hFE1, "R5");
    op(1, 8'hE9, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R8 nested postinc");
    acc(8'hE8, 0, "R8 inc after nested");

    // R9 strobe combinations
    ldp(0, 12'h040, "R5");
    for (int k = 0; k < 16; k++)
      op(k[3], 8'hE0, 0, k[2], k[1], k[0], 0, 0, 0, 0, 0, "R9");
    for (int k = 0; k < 16; k++)
      op(k[3], 8'h22, k[2], k[1], k[0], 1, 0, 0, 0, 0, 0, "R9 direct");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      rb = 4'($urandom);
      rv = ($urandom_range(0, 3) == 0) ? 12'hFE0 + 12'($urandom_range(0, 9)) : 12'($urandom);
      op($urandom_range(0, 7) != 0,
         ($urandom_range(0, 2) == 0) ? 8'hE0 + 8'($urandom_range(0, 9)) : 8'($urandom),
         1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
         $urandom_range(0, 5) == 0, rb, $urandom_range(0, 4) == 0,
         2'($urandom), rv, "R1-mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule